// File: doc/BRIEF.md
# Hierarchical Latched Interrupt Controller

This block gathers one-cycle event pulses from a set of line channels and from one serial-link source, and turns them into a single interrupt request for a host processor. Each event pulse sets a bit in a status byte. That bit stays set until the host reads the byte. Each status byte has a mask byte beside it. A channel summarises its masked, pending bytes in a request byte, with one bit per status byte. The host can read this request byte to find which status byte needs service, without scanning all the status bytes.

All request bytes, together with the serial source's own masked status, combine into one shared interrupt line. The line is modelled as a drive-low enable for an open-drain pad: when the enable is high the pad pulls the wire low, and when the enable is low the pad releases the wire. The host reaches every byte through a small register port. A read returns data one cycle after it is issued, and reading a status byte clears exactly the bits that the read returned.

Top module: `irq_hier_ctrl`

## Requirements
- R1: An event pulse on bit b of status byte r of channel c sets that status bit at the next clock edge. The bit stays set, whatever the mask and whatever writes occur, until the host reads that status byte.
- R2: A read of a status byte returns its value on `rd_data_o` one cycle after `rd_en_i`. At the same edge, every bit that was returned is cleared, so a second read returns 0 unless new events have arrived.
- R3: If an event arrives in the same cycle as a read of its status byte, the event is not lost. It is set after that edge and is returned by the next read.
- R4: Bit r of a channel's request byte is 1 exactly when (status byte r AND mask byte r) is non-zero. The request byte is read-only and always reflects the current state.
- R5: Clearing a mask bit removes that bit's contribution to the request byte and to the interrupt line, but leaves the latched status bit unchanged.
- R6: `irq_drv_o` is 1 (pull the line low) when any channel's request byte is non-zero or the serial source has a masked pending bit. Otherwise it is 0 (line released). The serial source is a status/mask pair at select 8. Its request byte reads as {7'b0, pending}.
- R7: A mask byte reads back the value last written to it. Writes to status bytes and to request bytes have no effect.
- R8: Reset clears all status and mask bytes and `rd_data_o`, and sets `irq_drv_o` to 0. The reset is asynchronous and active low.
- R9: Address map: `addr_i[8:5]` is the select (0 to 7 for a channel, 8 for the serial source), `addr_i[4:3]` is the kind (0 = status, 1 = mask, 2 = request), and `addr_i[2:0]` is the byte index. Event bit layout: bit (c*8+r)*8+b of `ev_i`. A read of kind 3, or of a select above 8, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 512 | Channel event pulses, bit (c*8+r)*8+b |
| ser_ev_i | input | 8 | Serial source event pulses |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 9 | Register address {select, kind, index} |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid one cycle after the read |
| irq_drv_o | output | 1 | Drive-low enable of the shared interrupt line |

## Verification
An event sampled at edge k is in the status byte after edge k. The request byte and `irq_drv_o` follow it without any extra register, so the bench checks them at the falling edge that follows edge k. A read issued at edge k has its data on `rd_data_o` after that edge, and the clear happens at the same edge. The bench therefore samples each read result half a cycle later and issues any follow-up read in the next cycle. The checker compares the read data with the status value held before the read edge, and it checks stickiness only on edges that carry no status read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    KIND_STS  = 2'd0,
    KIND_MASK = 2'd1,
    KIND_REQ  = 2'd2,
    KIND_NONE = 2'd3
  } kind_e;
  localparam int KIND_W = 2;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] msk_o,
  output logic         hit_o
);
  logic [W-1:0] sts_q, msk_q, sts_nxt;

  function automatic logic masked_any(input logic [W-1:0] s, input logic [W-1:0] m);
    return |(s & m);
  endfunction

  // a read clears exactly what it returned; coincident events survive
  always_comb begin
    if (clr_i) sts_nxt = ev_i;
    else       sts_nxt = sts_q | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= sts_nxt;
      if (we_i) msk_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign hit_o = masked_any(sts_q, msk_q);
endmodule

// File: rtl/irq_channel.sv
module irq_channel #(
  parameter int NREG = 8,
  parameter int W    = 8,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] ev_i,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [W-1:0]      wdata_i,
  output logic [NREG*W-1:0] sts_o,
  output logic [NREG*W-1:0] msk_o,
  output logic [NREG-1:0]   req_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_bank
    logic hit_idx;
    assign hit_idx = (idx_i == IDX_W'(r));
    irq_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_i    (ev_i[r*W +: W]),
      .clr_i   (clr_i && hit_idx),
      .we_i    (we_i && hit_idx),
      .wdata_i (wdata_i),
      .sts_o   (sts_o[r*W +: W]),
      .msk_o   (msk_o[r*W +: W]),
      .hit_o   (req_o[r])
    );
  end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl #(
  parameter int NUM_CH  = 8,
  parameter int NUM_REG = 8,
  parameter int REG_W   = 8,
  localparam int SEL_W  = $clog2(NUM_CH + 1),
  localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int AW     = SEL_W + irq_pkg::KIND_W + IDX_W,
  localparam int EV_W   = NUM_CH * NUM_REG * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  ev_i,
  input  logic [REG_W-1:0] ser_ev_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_drv_o
);
  import irq_pkg::*;

  logic [SEL_W-1:0] a_sel;
  kind_e            a_kind;
  logic [IDX_W-1:0] a_idx;

  assign a_idx  = addr_i[IDX_W-1:0];
  assign a_kind = kind_e'(addr_i[IDX_W +: KIND_W]);
  assign a_sel  = addr_i[AW-1 -: SEL_W];

  // named internal state for the checker
  logic [EV_W-1:0]           sts_flat, msk_flat;
  logic [NUM_CH*NUM_REG-1:0] req_flat;
  logic [REG_W-1:0]          ser_sts, ser_msk;
  logic                      ser_pend;
  logic                      ser_clr, ser_we;

  function automatic int byte_base(input logic [SEL_W-1:0] s, input logic [IDX_W-1:0] i);
    return (int'(s) * NUM_REG + int'(i)) * REG_W;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_me;
    assign sel_me = (a_sel == SEL_W'(c));
    irq_channel #(.NREG(NUM_REG), .W(REG_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_i    (ev_i[c*NUM_REG*REG_W +: NUM_REG*REG_W]),
      .clr_i   (rd_en_i && sel_me && (a_kind == KIND_STS)),
      .we_i    (wr_en_i && sel_me && (a_kind == KIND_MASK)),
      .idx_i   (a_idx),
      .wdata_i (wr_data_i),
      .sts_o   (sts_flat[c*NUM_REG*REG_W +: NUM_REG*REG_W]),
      .msk_o   (msk_flat[c*NUM_REG*REG_W +: NUM_REG*REG_W]),
      .req_o   (req_flat[c*NUM_REG +: NUM_REG])
    );
  end

  assign ser_clr = rd_en_i && (a_sel == SEL_W'(NUM_CH)) && (a_kind == KIND_STS) && (a_idx == '0);
  assign ser_we  = wr_en_i && (a_sel == SEL_W'(NUM_CH)) && (a_kind == KIND_MASK) && (a_idx == '0);

  irq_bank #(.W(REG_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ser_ev_i),
    .clr_i   (ser_clr),
    .we_i    (ser_we),
    .wdata_i (wr_data_i),
    .sts_o   (ser_sts),
    .msk_o   (ser_msk),
    .hit_o   (ser_pend)
  );

  // read mux
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(a_sel) < NUM_CH) begin
      unique case (a_kind)
        KIND_STS:  rd_mux = sts_flat[byte_base(a_sel, a_idx) +: REG_W];
        KIND_MASK: rd_mux = msk_flat[byte_base(a_sel, a_idx) +: REG_W];
        KIND_REQ:  if (a_idx == '0)
                     rd_mux = REG_W'(req_flat[int'(a_sel)*NUM_REG +: NUM_REG]);
        default:   rd_mux = '0;
      endcase
    end else if (int'(a_sel) == NUM_CH && a_idx == '0) begin
      unique case (a_kind)
        KIND_STS:  rd_mux = ser_sts;
        KIND_MASK: rd_mux = ser_msk;
        KIND_REQ:  rd_mux = REG_W'(ser_pend);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end

  assign irq_drv_o = (|req_flat) || ser_pend;
endmodule

// File: rtl/irq_hier_chk.sv
module irq_hier_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_REG = 8,
  parameter int REG_W   = 8,
  localparam int SEL_W  = $clog2(NUM_CH + 1),
  localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int AW     = SEL_W + 2 + IDX_W,
  localparam int EV_W   = NUM_CH * NUM_REG * REG_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [EV_W-1:0]           ev_i,
  input logic                      rd_en_i,
  input logic [AW-1:0]             addr_i,
  input logic [REG_W-1:0]          rd_data_o,
  input logic                      irq_drv_o,
  input logic [EV_W-1:0]           sts_flat,
  input logic [NUM_CH*NUM_REG-1:0] req_flat,
  input logic [REG_W-1:0]          ser_sts
);
  logic             sts_rd;
  logic [REG_W-1:0] sts_byte;
  logic [SEL_W-1:0] c_sel;
  logic [IDX_W-1:0] c_idx;

  assign c_sel  = addr_i[AW-1 -: SEL_W];
  assign c_idx  = addr_i[IDX_W-1:0];
  assign sts_rd = rd_en_i && (addr_i[IDX_W +: 2] == 2'd0) && (int'(c_sel) < NUM_CH);
  always_comb begin
    sts_byte = '0;
    if (int'(c_sel) < NUM_CH)
      sts_byte = sts_flat[(int'(c_sel) * NUM_REG + int'(c_idx)) * REG_W +: REG_W];
  end

  // R1
  ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sts_flat & $past(ev_i)) == $past(ev_i)));

  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sts_rd)) |-> ((sts_flat & $past(sts_flat)) == $past(sts_flat)));

  // R2
  rd_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sts_rd)) |-> (rd_data_o == $past(sts_byte)));

  // R6
  irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_flat) |-> irq_drv_o);

  // R6
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_flat == '0) && (ser_sts == '0)) |-> !irq_drv_o);

  // R8
  reset_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq_drv_o && rd_data_o == '0));
endmodule

bind irq_hier_ctrl irq_hier_chk #(
  .NUM_CH (NUM_CH),
  .NUM_REG(NUM_REG),
  .REG_W  (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_i      (ev_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .irq_drv_o (irq_drv_o),
  .sts_flat  (sts_flat),
  .req_flat  (req_flat),
  .ser_sts   (ser_sts)
);

// File: tb/irq_hier_ctrl_test.sv
module irq_hier_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] ev = '0;
  logic [7:0]   ser_ev = '0;
  logic         rd_en = 1'b0, wr_en = 1'b0;
  logic [8:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rd_data;
  logic         irq_drv;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hier_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .ser_ev_i(ser_ev),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rd_data), .irq_drv_o(irq_drv)
  );

  // {op, addr, value, req}; op 0=event 1=write 2=read 3=irq check
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 9'h000, 8'h05, 4'd1},  // R1 ch0 sts0
    {2'd3, 9'h000, 8'h00, 4'd6},  // R6 masked off
    {2'd1, 9'h008, 8'h04, 4'd7},  // R7 mask ch0/0
    {2'd3, 9'h000, 8'h01, 4'd6},  // R6
    {2'd2, 9'h010, 8'h01, 4'd4},  // R4 request ch0
    {2'd2, 9'h008, 8'h04, 4'd7},  // R7 readback
    {2'd2, 9'h000, 8'h05, 4'd2},  // R2 read
    {2'd2, 9'h000, 8'h00, 4'd2},  // R2 cleared
    {2'd3, 9'h000, 8'h00, 4'd6},  // R6
    {2'd0, 9'h0E3, 8'h80, 4'd1},  // R1 ch7 sts3
    {2'd1, 9'h0EB, 8'hFF, 4'd7},  // R7
    {2'd2, 9'h0F0, 8'h08, 4'd4},  // R4 bit 3
    {2'd3, 9'h000, 8'h01, 4'd6},  // R6
    {2'd1, 9'h0EB, 8'h00, 4'd5},  // R5 unmask
    {2'd3, 9'h000, 8'h00, 4'd5},  // R5
    {2'd2, 9'h0E3, 8'h80, 4'd5},  // R5 still latched
    {2'd0, 9'h100, 8'h02, 4'd6},  // R6 serial event
    {2'd3, 9'h000, 8'h00, 4'd6},  // R6
    {2'd1, 9'h108, 8'h02, 4'd6},  // R6 serial mask
    {2'd3, 9'h000, 8'h01, 4'd6},  // R6
    {2'd2, 9'h110, 8'h01, 4'd6},  // R6 serial request
    {2'd2, 9'h100, 8'h02, 4'd2},  // R2 serial read
    {2'd3, 9'h000, 8'h00, 4'd6},  // R6
    {2'd1, 9'h000, 8'hFF, 4'd7},  // R7 write status
    {2'd2, 9'h000, 8'h00, 4'd7},  // R7
    {2'd1, 9'h010, 8'hFF, 4'd7},  // R7 write request
    {2'd2, 9'h010, 8'h00, 4'd7},  // R7
    {2'd2, 9'h018, 8'h00, 4'd9},  // R9 kind 3
    {2'd2, 9'h120, 8'h00, 4'd9}   // R9 select 9
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put_ev(input logic [8:0] a, input logic [7:0] v);
    if (a[8:5] == 4'd8) ser_ev = v;
    else ev[(int'(a[8:5]) * 8 + int'(a[2:0])) * 8 +: 8] = v;
  endtask

  task automatic run(input logic [1:0] op, input logic [8:0] a, input logic [7:0] v, input string tag);
    case (op)
      2'd0: begin put_ev(a, v); @(negedge clk); ev = '0; ser_ev = '0; end
      2'd1: begin addr = a; wdata = v; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0; end
      2'd2: begin addr = a; rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; check(tag, rd_data, v); end
      default: check(tag, {7'b0, irq_drv}, v);
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 irq in reset", {7'b0, irq_drv}, 8'h00);
    check("R8 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd2, 9'h008, 8'h00, "R8 mask after reset");

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
      run(VEC[i][22:21], VEC[i][20:12], VEC[i][11:4], t);
    end

    // R3: event coinciding with a read
    run(2'd0, 9'h022, 8'h01, "R3 setup");
    put_ev(9'h022, 8'h03); addr = 9'h022; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; ev = '0;
    check("R3 read returns old", rd_data, 8'h01);
    run(2'd2, 9'h022, 8'h03, "R3 event kept");

    // R8: reset in mid-run
    run(2'd0, 9'h045, 8'hFF, "R8 setup");
    run(2'd1, 9'h04D, 8'hFF, "R8 setup");
    run(2'd3, 9'h000, 8'h01, "R8 irq before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 irq released", {7'b0, irq_drv}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd2, 9'h04D, 8'h00, "R8 mask cleared");
    run(2'd2, 9'h045, 8'h00, "R8 status cleared");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule